// File: doc/BRIEF.md
# Receive Sampling-Tap Calibration Sequencer

This block finds a safe receive sampling delay for a double-data-rate serial flash read path. After a start pulse it brings up the delay-locked loop that produces the receive delay. It then sweeps every receive tap. At each tap it asks an external read engine for the device identifier several times, and the engine returns a match flag that compares the result with a stored golden value. Runs of passing taps form windows, and each window is sized from the tap value that the delay line reports back.

The sweep runs once with no extra dummy cycle and once with one extra dummy cycle. The block keeps the widest window it has seen. At the end it programs the midpoint of that window and latches the dummy-cycle setting that produced it. A sweep ends early once a window wide enough to survive drift has closed. If no window reaches that width, or if any lock flag fails to arrive in time, the block reports failure and stays untuned.

Top module: `rx_tap_calib`

## Requirements
- R1: After reset, `done`, `fail` and `rd_req` are 0, `phy_cfg` is 0, `master_dly` is 0 and `extra_dummy` is 0.
- R2: After `start`, bring-up runs in this order:
  - `phy_cfg` goes to 0.
  - `master_dly` is loaded with 4.
  - `phy_cfg` becomes 0x40000000 (bit 30 is the DLL reset field).
  - The block waits for `lpbk_lock`.
  - `phy_cfg` becomes 0xC0000000 (bit 31 is resync).
- R3: For each tap, `phy_cfg` is first written with bit 30 set, bits 29:16 equal to 0x1E and the tap index in bits 6:0. It is then written again with bit 31 also set. No read is requested until `dll_lock` is seen, and the word stays unchanged while reads are in progress.
- R4: A tap passes only if 10 consecutive read responses all have `rd_id_match`=1. The first response with `rd_id_match`=0 rejects the tap, and no further read is issued for that tap.
- R5: A window closes when a tap fails after at least one pass, or when tap 127 is evaluated. Its size is the `obs_tap` value sampled at the last passing tap, minus the value sampled at the first passing tap, plus 1.
- R6: A sweep stops as soon as a window of size 3 or more closes. No higher tap of that sweep is visited.
- R7: Two sweeps run, each starting at tap 0: first with `extra_dummy`=0, then with `extra_dummy`=1. `extra_dummy` equals the current sweep's setting during every read.
- R8: The widest window over both sweeps wins. The programmed tap is (first index + last index) / 2, rounded down, and `extra_dummy` is latched to the winning sweep's setting.
- R9: A window replaces the current best only if it is strictly larger. On a tie, the earlier window wins.
- R10: If the best window is narrower than 3, `fail` is raised and `extra_dummy` returns to 0.
- R11: On success, `phy_cfg` is programmed to 0xC01E0000 OR the chosen tap. The block then waits for `dll_lock` and raises `done`.
- R12: If `lpbk_lock` or `dll_lock` stays low for 64 cycles, `fail` is raised, `done` stays 0 and no further read request is issued.
- R13: `done` and `fail` are never both 1. Each holds its value until the next `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin calibration (pulse, accepted when idle) |
| done | output | 1 | Calibration succeeded |
| fail | output | 1 | Calibration failed or a lock timed out |
| rd_req | output | 1 | One-cycle request for a device-ID read |
| rd_resp_valid | input | 1 | Read response strobe |
| rd_id_match | input | 1 | Read result equals golden ID (valid with strobe) |
| lpbk_lock | input | 1 | Loopback lock flag of the DLL |
| dll_lock | input | 1 | DLL lock flag |
| obs_tap | input | 7 | Receive tap reported back by the delay line |
| phy_cfg | output | 32 | PHY configuration word |
| master_dly | output | 8 | DLL master delay setting |
| extra_dummy | output | 1 | Extra dummy cycle for reads |

## Verification
The checker module tests these properties on every cycle:
- Each read request comes with a fully configured, resynchronised word that is stable while the read runs.
- Requests are single-cycle and stop once `fail` is up.
- `done` rises only after a lock.
- `done` and `fail` are exclusive.

Window sizing, the early stop, the choice between sweeps with its tie rule, the midpoint arithmetic and the 10-read qualification depend on whole sweeps. Only the directed scenarios show them, because they feed chosen pass maps, flaky reads and a non-linear observed tap and then compare the final word and dummy setting.

// File: rtl/rx_tap_calib_pkg.sv
package rx_tap_calib_pkg;

    localparam int TAP_W = 7;
    localparam int DLY_W = 8;
    localparam int TXD_W = 14;

    // configuration word: [31] resync, [30] dll reset, [29:16] tx delay, [6:0] rx tap
    typedef struct packed {
        logic             resync;
        logic             dll_rst;
        logic [TXD_W-1:0] tx_dly;
        logic [8:0]       pad;
        logic [TAP_W-1:0] rx_tap;
    } phy_word_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BR_LOW,
        ST_BR_MDLY,
        ST_BR_RST,
        ST_BR_LPBK,
        ST_BR_RSYNC,
        ST_TAP_CFG,
        ST_TAP_RSYNC,
        ST_TAP_LOCK,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_TAP_EVAL,
        ST_FIN_DECIDE,
        ST_FIN_RSYNC,
        ST_FIN_LOCK
    } cal_state_t;

    function automatic phy_word_t mk_word(input logic [TXD_W-1:0] tx,
                                          input logic rsy,
                                          input logic rs,
                                          input logic [TAP_W-1:0] tap);
        phy_word_t w;
        w        = '0;
        w.resync = rsy;
        w.dll_rst = rs;
        w.tx_dly = tx;
        w.rx_tap = tap;
        return w;
    endfunction

endpackage

// File: rtl/calib_lock_timer.sv
module calib_lock_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = waiting && (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !waiting) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/calib_window_track.sv
module calib_window_track #(
    parameter int TAP_W   = 7,
    parameter int MIN_WIN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             eval,
    input  logic             pass,
    input  logic             is_last,
    input  logic             dummy,
    input  logic [TAP_W-1:0] idx,
    input  logic [TAP_W-1:0] obs,
    output logic             stop,
    output logic [TAP_W:0]   best_size,
    output logic [TAP_W-1:0] best_idx,
    output logic             best_dummy
);
    logic             found;
    logic [TAP_W-1:0] first_obs, last_obs, first_idx, last_idx;
    logic [TAP_W-1:0] f_obs, l_obs, f_idx, l_idx;
    logic [TAP_W:0]   size, idx_sum;
    logic             close;

    always_comb begin
        f_obs   = (pass && !found) ? obs : first_obs;
        f_idx   = (pass && !found) ? idx : first_idx;
        l_obs   = pass ? obs : last_obs;
        l_idx   = pass ? idx : last_idx;
        close   = eval && (found || pass) && (!pass || is_last);
        size    = {1'b0, l_obs} - {1'b0, f_obs} + 1'b1;
        idx_sum = {1'b0, f_idx} + {1'b0, l_idx};
        stop    = close && (size >= (TAP_W+1)'(MIN_WIN));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            found      <= 1'b0;
            first_obs  <= '0;
            last_obs   <= '0;
            first_idx  <= '0;
            last_idx   <= '0;
            best_size  <= '0;
            best_idx   <= '0;
            best_dummy <= 1'b0;
        end else if (eval) begin
            if (close) begin
                found <= 1'b0;
                if (size > best_size) begin
                    best_size  <= size;
                    best_idx   <= idx_sum[TAP_W:1];
                    best_dummy <= dummy;
                end
            end else if (pass) begin
                found     <= 1'b1;
                first_obs <= f_obs;
                first_idx <= f_idx;
                last_obs  <= l_obs;
                last_idx  <= l_idx;
            end
        end
    end
endmodule

// File: rtl/rx_tap_calib.sv
module rx_tap_calib
    import rx_tap_calib_pkg::*;
#(
    parameter int READS_PER_TAP = 10,
    parameter int MIN_WIN       = 3,
    parameter int TX_DLY        = 'h1E,
    parameter int INIT_DLY      = 4,
    parameter int LOCK_TIMEOUT  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             done,
    output logic             fail,
    output logic             rd_req,
    input  logic             rd_resp_valid,
    input  logic             rd_id_match,
    input  logic             lpbk_lock,
    input  logic             dll_lock,
    input  logic [TAP_W-1:0] obs_tap,
    output logic [31:0]      phy_cfg,
    output logic [DLY_W-1:0] master_dly,
    output logic             extra_dummy
);
    localparam int RC_W = $clog2(READS_PER_TAP);
    localparam logic [TXD_W-1:0] TXV = TXD_W'(TX_DLY);

    cal_state_t       state;
    phy_word_t        cfg_q;
    logic [TAP_W-1:0] tap;
    logic [RC_W-1:0]  rd_cnt;
    logic             tap_pass;
    logic             waiting, expired;
    logic             win_stop, best_dummy, is_last, clr;
    logic [TAP_W:0]   best_size;
    logic [TAP_W-1:0] best_idx;

    assign phy_cfg = cfg_q;
    assign is_last = (tap == {TAP_W{1'b1}});
    assign clr     = (state == ST_IDLE) && start;
    assign waiting = ((state == ST_BR_LPBK) && !lpbk_lock) ||
                     (((state == ST_TAP_LOCK) || (state == ST_FIN_LOCK)) && !dll_lock);

    calib_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .waiting (waiting),
        .expired (expired)
    );

    calib_window_track #(.TAP_W(TAP_W), .MIN_WIN(MIN_WIN)) u_win (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .eval       (state == ST_TAP_EVAL),
        .pass       (tap_pass),
        .is_last    (is_last),
        .dummy      (extra_dummy),
        .idx        (tap),
        .obs        (obs_tap),
        .stop       (win_stop),
        .best_size  (best_size),
        .best_idx   (best_idx),
        .best_dummy (best_dummy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cfg_q       <= '0;
            master_dly  <= '0;
            tap         <= '0;
            rd_cnt      <= '0;
            tap_pass    <= 1'b0;
            done        <= 1'b0;
            fail        <= 1'b0;
            rd_req      <= 1'b0;
            extra_dummy <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    done        <= 1'b0;
                    fail        <= 1'b0;
                    extra_dummy <= 1'b0;
                    state       <= ST_BR_LOW;
                end
                ST_BR_LOW: begin
                    cfg_q <= '0;
                    state <= ST_BR_MDLY;
                end
                ST_BR_MDLY: begin
                    master_dly <= DLY_W'(INIT_DLY);
                    state      <= ST_BR_RST;
                end
                ST_BR_RST: begin
                    cfg_q <= mk_word('0, 1'b0, 1'b1, '0);
                    state <= ST_BR_LPBK;
                end
                ST_BR_LPBK: begin
                    if (lpbk_lock) begin
                        state <= ST_BR_RSYNC;
                    end else if (expired) begin
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_BR_RSYNC: begin
                    cfg_q <= mk_word('0, 1'b1, 1'b1, '0);
                    tap   <= '0;
                    state <= ST_TAP_CFG;
                end
                ST_TAP_CFG: begin
                    cfg_q <= mk_word(TXV, 1'b0, 1'b1, tap);
                    state <= ST_TAP_RSYNC;
                end
                ST_TAP_RSYNC: begin
                    cfg_q.resync <= 1'b1;
                    state        <= ST_TAP_LOCK;
                end
                ST_TAP_LOCK: begin
                    if (dll_lock) begin
                        rd_cnt <= '0;
                        state  <= ST_RD_ISSUE;
                    end else if (expired) begin
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_RD_ISSUE: begin
                    rd_req <= 1'b1;
                    state  <= ST_RD_WAIT;
                end
                ST_RD_WAIT: if (rd_resp_valid) begin
                    if (!rd_id_match) begin
                        tap_pass <= 1'b0;
                        state    <= ST_TAP_EVAL;
                    end else if (rd_cnt == RC_W'(READS_PER_TAP - 1)) begin
                        tap_pass <= 1'b1;
                        state    <= ST_TAP_EVAL;
                    end else begin
                        rd_cnt <= rd_cnt + 1'b1;
                        state  <= ST_RD_ISSUE;
                    end
                end
                ST_TAP_EVAL: begin
                    if (win_stop || is_last) begin
                        if (!extra_dummy) begin
                            extra_dummy <= 1'b1;
                            tap         <= '0;
                            state       <= ST_TAP_CFG;
                        end else begin
                            state <= ST_FIN_DECIDE;
                        end
                    end else begin
                        tap   <= tap + 1'b1;
                        state <= ST_TAP_CFG;
                    end
                end
                ST_FIN_DECIDE: begin
                    if (best_size < (TAP_W+1)'(MIN_WIN)) begin
                        fail        <= 1'b1;
                        extra_dummy <= 1'b0;
                        state       <= ST_IDLE;
                    end else begin
                        extra_dummy <= best_dummy;
                        cfg_q       <= mk_word(TXV, 1'b0, 1'b1, best_idx);
                        state       <= ST_FIN_RSYNC;
                    end
                end
                ST_FIN_RSYNC: begin
                    cfg_q.resync <= 1'b1;
                    state        <= ST_FIN_LOCK;
                end
                ST_FIN_LOCK: begin
                    if (dll_lock) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (expired) begin
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_tap_calib_chk.sv
module rx_tap_calib_chk #(
    parameter int TX_DLY = 'h1E
) (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic        fail,
    input logic        rd_req,
    input logic        dll_lock,
    input logic [31:0] phy_cfg
);
    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fail)); // R13

    AST_REQ_CONFIGURED: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (phy_cfg[31] && phy_cfg[30] && (phy_cfg[29:16] == 14'(TX_DLY)))); // R3

    AST_REQ_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> $stable(phy_cfg)); // R3

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R4

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        fail |-> !rd_req); // R12

    AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(dll_lock) && phy_cfg[31] && phy_cfg[30])); // R11
endmodule

bind rx_tap_calib rx_tap_calib_chk #(.TX_DLY(TX_DLY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .fail     (fail),
    .rd_req   (rd_req),
    .dll_lock (dll_lock),
    .phy_cfg  (phy_cfg)
);

// File: tb/rx_tap_calib_test.sv
`timescale 1ns/1ps
module rx_tap_calib_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done, fail, rd_req, extra_dummy;
    logic        rd_resp_valid = 1'b0;
    logic        rd_id_match = 1'b0;
    logic        lpbk_lock = 1'b1;
    logic        dll_lock = 1'b1;
    logic [6:0]  obs_tap;
    logic [31:0] phy_cfg;
    logic [7:0]  master_dly;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic pm [0:1][0:127];
    int   rcount [0:1][0:127];
    int   flaky_t, flaky_n, sw, dmis, total_rd, last_t, last_d, nrd;
    bit   fresh, obs_dbl, logging;
    logic [31:0] log_cfg [0:7];
    logic [7:0]  log_mdly [0:7];
    logic [31:0] prev_cfg;
    int   nlog;

    always #4 clk = ~clk;

    assign obs_tap = obs_dbl ? {phy_cfg[5:0], 1'b0} : phy_cfg[6:0];

    rx_tap_calib uut (
        .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
        .rd_req(rd_req), .rd_resp_valid(rd_resp_valid), .rd_id_match(rd_id_match),
        .lpbk_lock(lpbk_lock), .dll_lock(dll_lock), .obs_tap(obs_tap),
        .phy_cfg(phy_cfg), .master_dly(master_dly), .extra_dummy(extra_dummy)
    );

    // read engine model: one-cycle response latency
    always @(posedge clk) begin
        int t, d;
        rd_resp_valid <= 1'b0;
        if (rd_req) begin
            t = int'(phy_cfg[6:0]);
            d = int'(extra_dummy);
            if (!fresh && t == last_t && d == last_d) nrd = nrd + 1;
            else nrd = 1;
            if (!fresh && t < last_t) sw = sw + 1;
            fresh = 0;
            last_t = t;
            last_d = d;
            if (d != sw) dmis = dmis + 1;
            rcount[d][t] = rcount[d][t] + 1;
            total_rd = total_rd + 1;
            rd_resp_valid <= 1'b1;
            rd_id_match <= pm[d][t] && !(t == flaky_t && nrd == flaky_n);
        end
    end

    always @(posedge clk) begin
        if (logging && phy_cfg != prev_cfg) begin
            if (nlog < 8) begin
                log_cfg[nlog]  = phy_cfg;
                log_mdly[nlog] = master_dly;
            end
            nlog = nlog + 1;
        end
        prev_cfg = phy_cfg;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int d = 0; d < 2; d++)
            for (int t = 0; t < 128; t++) begin
                pm[d][t] = 1'b0;
                rcount[d][t] = 0;
            end
        flaky_t = 200; flaky_n = 0; sw = 0; dmis = 0; total_rd = 0;
        fresh = 1; obs_dbl = 0; nrd = 0; last_t = 0; last_d = 0;
    endtask

    task automatic set_win(input int d, input int lo, input int hi);
        for (int t = lo; t <= hi; t++) pm[d][t] = 1'b1;
    endtask

    task automatic run_cal();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (done || fail) return;
            @(negedge clk);
        end
        chk("R13 run did not end", 32'(done | fail), 32'd1);
    endtask

    task automatic expect_tuned(input string req, input int tap, input int dmy);
        chk({req, " done"}, 32'(done), 32'd1);
        chk({req, " fail"}, 32'(fail), 32'd0);
        chk({req, " phy_cfg"}, phy_cfg, 32'hC01E0000 | 32'(tap));
        chk({req, " extra_dummy"}, 32'(extra_dummy), 32'(dmy));
        chk("R7 dummy during sweep", 32'(dmis), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 fail", 32'(fail), 32'd0);
        chk("R1 rd_req", 32'(rd_req), 32'd0);
        chk("R1 phy_cfg", phy_cfg, 32'd0);
        chk("R1 master_dly", 32'(master_dly), 32'd0);
        chk("R1 extra_dummy", 32'(extra_dummy), 32'd0);
    endtask

    task automatic t_basic();
        clear_model();
        set_win(0, 20, 29);
        nlog = 0; logging = 1;
        run_cal();
        logging = 0;
        chk("R2 step reset", log_cfg[0], 32'h40000000);
        chk("R2 master delay before reset", 32'(log_mdly[0]), 32'd4);
        chk("R2 step resync", log_cfg[1], 32'hC0000000);
        chk("R3 tap0 word", log_cfg[2], 32'h401E0000);
        chk("R3 tap0 resync", log_cfg[3], 32'hC01E0000);
        chk("R2 master_dly", 32'(master_dly), 32'd4);
        chk("R4 reads on passing tap", 32'(rcount[0][20]), 32'd10);
        chk("R4 reads on failing tap", 32'(rcount[0][19]), 32'd1);
        chk("R6 early stop tap 30 visited", 32'(rcount[0][30]), 32'd1);
        chk("R6 no tap 31 in sweep 0", 32'(rcount[0][31]), 32'd0);
        chk("R7 second sweep ran to end", 32'(rcount[1][127]), 32'd1);
        expect_tuned("R11", 24, 0);
        repeat (20) @(negedge clk);
        chk("R13 done held", 32'(done), 32'd1);
    endtask

    task automatic t_dummy_wins();
        clear_model();
        set_win(0, 5, 6);
        set_win(1, 40, 47);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R13 start clears done", 32'(done), 32'd0);
        for (int i = 0; i < 20000 && !(done || fail); i++) @(negedge clk);
        chk("R5 narrow window did not stop sweep 0", 32'(rcount[0][127]), 32'd1);
        expect_tuned("R8", 43, 1);
    endtask

    task automatic t_tie();
        clear_model();
        set_win(0, 100, 103);
        set_win(1, 10, 13);
        run_cal();
        expect_tuned("R9", 101, 0);
    endtask

    task automatic t_narrow_fail();
        clear_model();
        set_win(0, 0, 1);
        set_win(0, 126, 127);
        set_win(1, 50, 51);
        run_cal();
        chk("R10 fail", 32'(fail), 32'd1);
        chk("R10 done", 32'(done), 32'd0);
        chk("R10 extra_dummy", 32'(extra_dummy), 32'd0);
        repeat (20) @(negedge clk);
        chk("R13 fail held", 32'(fail), 32'd1);
    endtask

    task automatic t_last_tap();
        clear_model();
        set_win(0, 124, 127);
        run_cal();
        expect_tuned("R5 window closed at tap 127", 125, 0);
    endtask

    task automatic t_obs_size();
        clear_model();
        set_win(0, 60, 61);
        obs_dbl = 1;
        run_cal();
        chk("R5 size from observed tap stops sweep", 32'(rcount[0][63]), 32'd0);
        expect_tuned("R5", 60, 0);
    endtask

    task automatic t_flaky();
        clear_model();
        set_win(0, 30, 35);
        flaky_t = 30; flaky_n = 10;
        run_cal();
        chk("R4 flaky tap read ten times", 32'(rcount[0][30]), 32'd10);
        expect_tuned("R4", 33, 0);
    endtask

    task automatic t_timeout();
        clear_model();
        set_win(0, 10, 20);
        dll_lock = 1'b0;
        run_cal();
        chk("R12 fail", 32'(fail), 32'd1);
        chk("R12 done", 32'(done), 32'd0);
        repeat (20) @(negedge clk);
        chk("R12 no reads", 32'(total_rd), 32'd0);
        dll_lock = 1'b1;
        clear_model();
        lpbk_lock = 1'b0;
        run_cal();
        chk("R12 loopback timeout fail", 32'(fail), 32'd1);
        chk("R12 loopback no reads", 32'(total_rd), 32'd0);
        lpbk_lock = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logging = 0; nlog = 0; prev_cfg = '0;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dummy_wins();
        t_tie();
        t_narrow_fail();
        t_last_tap();
        t_obs_size();
        t_flaky();
        t_timeout();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule